// File: doc/BRIEF.md
# High-Voltage Rail Sequencer

This block sequences the three high-voltage rails that feed a micromirror array: an offset rail, a bias rail and a reset rail. When the projection-enable input goes high, the block turns on the low-voltage supply and waits for a supply-good input. It then brings up the offset rail first, the bias rail next and the reset rail last. Each of the two power-up gaps is set by a register field in milliseconds. The array reset is released only once all three rails are on.

There are two ways to shut down. When projection-enable is removed, the block runs a slow, fixed power-down. The bias and reset rails stop after 25 ms. The offset rail stops 10 ms after that, and the array reset asserts with it. One millisecond later all three rails are discharged, and the low-voltage supply is switched off after that. When the fault input rises, the interrupt goes low. The bias and reset rails then stop after one programmable delay, and all rails are discharged after a second programmable delay. The block then waits in standby until the fault input clears, and restarts the full power-up. A control bit turns the fast path off, so that a fault uses the slow timing instead.

Top module: `hv_rail_seq`

## Requirements
- R1: Out of reset, all three rail enables are 0, all three discharge outputs are 1, `mirror_rst_n` is 0, `irq_n` is 1, and `mirror_en` and `lv_supply_en` are 0. The register reset values are: control 1, stop delay 125, discharge delay 0, offset-stage code 1, bias-stage code 1.
- R2: Register map (3-bit address, 8-bit data; a write takes effect on the clock edge where `reg_we` is high; reads are combinational):
  - address 0: bit 0 is the fast-shutdown enable, and the other bits read as 0;
  - address 1: fault stop delay code;
  - address 2: fault discharge delay code;
  - address 3: offset-stage code;
  - address 4: bias-stage code.
  Writes to addresses 5 to 7 change nothing, and reads there return 0.
- R3: With no fault, a high `proj_en` sets `lv_supply_en` on the next edge. The offset rail and `mirror_en` turn on one edge after `lv_good` is seen high, and not before.
- R4: The bias rail turns on (offset-stage code + 1) ms after the offset rail. The reset rail turns on (bias-stage code + 1) ms after the bias rail, and `mirror_rst_n` rises in the same cycle as the reset rail.
- R5: The bias rail is never on without the offset rail, and the reset rail is never on without the bias rail.
- R6: When `proj_en` falls with no fault, the bias and reset rails turn off 25 ms later. The offset rail turns off 10 ms after that, and `mirror_rst_n` goes low in the same cycle. All three discharge outputs assert 1 ms after that, and `lv_supply_en` and `mirror_en` fall one cycle after the discharge.
- R7: `irq_n` stays high throughout a normal power-down. It goes low on the first edge after `fault` rises.
- R8: With fast shutdown enabled, the bias and reset rails turn off (stop code + 1) fast ticks after the fault is taken.
- R9: (discharge code + 1) fast ticks later, the offset rail turns off, all three rails discharge and `mirror_rst_n` goes low, all in one cycle. One cycle after that, `mirror_en` and `lv_supply_en` fall and the block is in standby.
- R10: The block stays in standby while `fault` is high. When `fault` clears, `irq_n` returns high and `lv_supply_en` rises on the next edge. The full power-up then runs again.
- R11: With fast shutdown disabled, a fault follows the R6 timing, and `irq_n` is held low.
- R12: A fault taken during power-up shuts down from the current rail state. A rail that was not yet on stays off.
- R13: A discharge output is never asserted while any rail enable is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proj_en | input | 1 | Projection enable request |
| lv_good | input | 1 | Low-voltage supplies are up |
| fault | input | 1 | Fault indication, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| offs_en | output | 1 | Offset rail regulation enable |
| bias_en | output | 1 | Bias rail regulation enable |
| rset_en | output | 1 | Reset rail regulation enable |
| offs_dis | output | 1 | Offset rail discharge |
| bias_dis | output | 1 | Bias rail discharge |
| rset_dis | output | 1 | Reset rail discharge |
| mirror_rst_n | output | 1 | Active-low array reset |
| irq_n | output | 1 | Active-low interrupt |
| mirror_en | output | 1 | Internal array enable |
| lv_supply_en | output | 1 | Low-voltage supply enable |

## Verification
The sequencer state is visible almost directly at the ports. A wrong state either moves a rail edge by a whole number of millisecond or fast ticks, or breaks the rail ordering in the very cycle the state is entered. The bench therefore times every rail, discharge and supply edge from the previous one in exact cycles, so an off-by-one timer limit or a skipped state shows up at the next edge. An illegal combination of outputs, such as a discharge output with a rail on or the bias rail on without the offset rail, is flagged by the assertions in the same cycle.

// File: rtl/hv_seq_pkg.sv
// Shared types and constants for the high-voltage rail sequencer.
// Assumes an 8-bit register data path and a 3-bit register address space.
package hv_seq_pkg;

    localparam int CODE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_STOP    = 3'd1;
    localparam logic [ADDR_W-1:0] A_DISCH   = 3'd2;
    localparam logic [ADDR_W-1:0] A_UP_OFFS = 3'd3;
    localparam logic [ADDR_W-1:0] A_UP_BIAS = 3'd4;

    typedef struct packed {
        logic              fast_en;
        logic [CODE_W-1:0] stop_code;
        logic [CODE_W-1:0] disch_code;
        logic [CODE_W-1:0] up_offs_code;
        logic [CODE_W-1:0] up_bias_code;
    } seq_cfg_t;

    typedef enum logic [3:0] {
        S_OFF, S_WAIT_LV, S_UP_OFFS, S_UP_BIAS, S_ON,
        S_DN_HOLD, S_DN_OFFS, S_DN_GAP, S_DN_DISCH,
        S_F_STOP, S_F_DIS, S_F_DISCH, S_STBY
    } seq_state_e;

endpackage

// File: rtl/hv_tick_timer.sv
// Interval timer: a prescaler divides the clock into ticks and a counter counts ticks.
// Assumes clr is pulsed on entry to every timed state, and limit >= 1 while timing.
// done pulses on the exact cycle of the limit-th tick after clr.
module hv_tick_timer #(
    parameter int DIV   = 50000,
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LIM_W-1:0] limit,
    output logic             done
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0]    presc_q;
    logic [LIM_W-1:0] cnt_q;
    logic             tick;

    assign tick = (presc_q == PW'(DIV - 1));
    assign done = tick && (cnt_q == limit - LIM_W'(1));

    // Prescaler: restarts on clr, wraps at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) presc_q <= '0;
        else                       presc_q <= presc_q + PW'(1);
    end

    // Tick counter: restarts on clr, advances once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        cnt_q <= '0;
        else if (tick && !done)   cnt_q <= cnt_q + LIM_W'(1);
    end
endmodule

// File: rtl/hv_seq_regs.sv
// Register file holding the fast-shutdown enable and the four delay codes.
// Assumes single-cycle writes; reads are combinational; unmapped addresses read 0.
module hv_seq_regs
    import hv_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] rdata,
    output seq_cfg_t          cfg
);
    // Field storage with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.fast_en      <= 1'b1;
            cfg.stop_code    <= CODE_W'(125);
            cfg.disch_code   <= '0;
            cfg.up_offs_code <= CODE_W'(1);
            cfg.up_bias_code <= CODE_W'(1);
        end else if (we) begin
            case (addr)
                A_CTRL:    cfg.fast_en      <= wdata[0];
                A_STOP:    cfg.stop_code    <= wdata;
                A_DISCH:   cfg.disch_code   <= wdata;
                A_UP_OFFS: cfg.up_offs_code <= wdata;
                A_UP_BIAS: cfg.up_bias_code <= wdata;
                default:   ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:    rdata = {{(CODE_W-1){1'b0}}, cfg.fast_en};
            A_STOP:    rdata = cfg.stop_code;
            A_DISCH:   rdata = cfg.disch_code;
            A_UP_OFFS: rdata = cfg.up_offs_code;
            A_UP_BIAS: rdata = cfg.up_bias_code;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/hv_rail_seq.sv
// High-voltage rail sequencer for a micromirror array: ordered power-up, slow timed
// power-down, fault fast power-down, standby and restart.
// Assumes fault, proj_en and lv_good are already synchronous to clk.
// Rail outputs are registers updated on entry to each state, so a fault abort
// keeps the rails of the state it interrupts.
module hv_rail_seq
    import hv_seq_pkg::*;
#(
    parameter int CLKS_PER_MS    = 50000,
    parameter int CLKS_PER_FTICK = 215,
    parameter int HOLD_MS        = 25,
    parameter int OFFS_MS        = 10,
    parameter int GAP_MS         = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proj_en,
    input  logic              lv_good,
    input  logic              fault,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CODE_W-1:0] reg_wdata,
    output logic [CODE_W-1:0] reg_rdata,
    output logic              offs_en,
    output logic              bias_en,
    output logic              rset_en,
    output logic              offs_dis,
    output logic              bias_dis,
    output logic              rset_dis,
    output logic              mirror_rst_n,
    output logic              irq_n,
    output logic              mirror_en,
    output logic              lv_supply_en
);
    localparam int LIM_W = CODE_W + 1;

    seq_cfg_t         cfg;
    seq_state_e       state_q, state_d;
    logic [LIM_W-1:0] ms_lim, ft_lim;
    logic             ms_done, ft_done, tmr_clr;
    logic             offs_q, bias_q, rset_q, dis_q, mrst_n_q, men_q, lv_q, flt_q;
    logic             offs_up, bias_up, rset_up, hi_drop, offs_drop;

    hv_seq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
    );

    hv_tick_timer #(.DIV(CLKS_PER_MS), .LIM_W(LIM_W)) u_ms_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(ms_lim), .done(ms_done)
    );

    hv_tick_timer #(.DIV(CLKS_PER_FTICK), .LIM_W(LIM_W)) u_ft_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(ft_lim), .done(ft_done)
    );

    // Interval length for the current state, in ms ticks and in fast ticks.
    always_comb begin
        ms_lim = LIM_W'(1);
        ft_lim = LIM_W'(1);
        case (state_q)
            S_UP_OFFS: ms_lim = {1'b0, cfg.up_offs_code} + LIM_W'(1);
            S_UP_BIAS: ms_lim = {1'b0, cfg.up_bias_code} + LIM_W'(1);
            S_DN_HOLD: ms_lim = LIM_W'(HOLD_MS);
            S_DN_OFFS: ms_lim = LIM_W'(OFFS_MS);
            S_DN_GAP:  ms_lim = LIM_W'(GAP_MS);
            S_F_STOP:  ft_lim = {1'b0, cfg.stop_code} + LIM_W'(1);
            S_F_DIS:   ft_lim = {1'b0, cfg.disch_code} + LIM_W'(1);
            default:   ;
        endcase
    end

    // Next-state logic; a fault takes priority over a projection-enable change.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_OFF:      if (fault) state_d = S_STBY;
                        else if (proj_en) state_d = S_WAIT_LV;
            S_STBY:     if (!fault) state_d = proj_en ? S_WAIT_LV : S_OFF;
            S_WAIT_LV:  if (!proj_en) state_d = S_OFF;
                        else if (lv_good) state_d = S_UP_OFFS;
            S_UP_OFFS:  if (!proj_en) state_d = S_DN_HOLD;
                        else if (ms_done) state_d = S_UP_BIAS;
            S_UP_BIAS:  if (!proj_en) state_d = S_DN_HOLD;
                        else if (ms_done) state_d = S_ON;
            S_ON:       if (!proj_en) state_d = S_DN_HOLD;
            S_DN_HOLD:  if (ms_done) state_d = S_DN_OFFS;
            S_DN_OFFS:  if (ms_done) state_d = S_DN_GAP;
            S_DN_GAP:   if (ms_done) state_d = S_DN_DISCH;
            S_DN_DISCH: state_d = S_OFF;
            S_F_STOP:   if (ft_done) state_d = S_F_DIS;
            S_F_DIS:    if (ft_done) state_d = S_F_DISCH;
            S_F_DISCH:  state_d = S_STBY;
            default:    state_d = S_OFF;
        endcase
        if (fault && (state_q inside {S_WAIT_LV, S_UP_OFFS, S_UP_BIAS, S_ON,
                                      S_DN_HOLD, S_DN_OFFS})) begin
            if (cfg.fast_en)
                state_d = S_F_STOP;
            else if (!(state_q inside {S_DN_HOLD, S_DN_OFFS}))
                state_d = S_DN_HOLD;
        end
    end

    assign tmr_clr   = (state_d != state_q);
    assign offs_up   = (state_q == S_WAIT_LV) && (state_d == S_UP_OFFS);
    assign bias_up   = (state_q == S_UP_OFFS) && (state_d == S_UP_BIAS);
    assign rset_up   = (state_q == S_UP_BIAS) && (state_d == S_ON);
    assign hi_drop   = state_d inside {S_DN_OFFS, S_DN_GAP, S_DN_DISCH, S_F_DIS,
                                       S_F_DISCH, S_OFF, S_STBY};
    assign offs_drop = state_d inside {S_DN_GAP, S_DN_DISCH, S_F_DISCH, S_OFF, S_STBY};

    // State register and registered rail, reset, interrupt and supply outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_OFF;
            offs_q   <= 1'b0;
            bias_q   <= 1'b0;
            rset_q   <= 1'b0;
            dis_q    <= 1'b1;
            mrst_n_q <= 1'b0;
            men_q    <= 1'b0;
            lv_q     <= 1'b0;
            flt_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            lv_q    <= !(state_d inside {S_OFF, S_STBY});
            dis_q   <= state_d inside {S_OFF, S_STBY, S_DN_DISCH, S_F_DISCH};
            flt_q   <= fault | (flt_q & !(state_q inside {S_OFF, S_STBY}));
            if (offs_up) begin
                offs_q <= 1'b1;
                men_q  <= 1'b1;
            end
            if (bias_up) bias_q <= 1'b1;
            if (rset_up) begin
                rset_q   <= 1'b1;
                mrst_n_q <= 1'b1;
            end
            if (hi_drop) begin
                bias_q <= 1'b0;
                rset_q <= 1'b0;
            end
            if (offs_drop) begin
                offs_q   <= 1'b0;
                mrst_n_q <= 1'b0;
            end
            if (state_d inside {S_OFF, S_STBY}) men_q <= 1'b0;
        end
    end

    assign offs_en      = offs_q;
    assign bias_en      = bias_q;
    assign rset_en      = rset_q;
    assign offs_dis     = dis_q;
    assign bias_dis     = dis_q;
    assign rset_dis     = dis_q;
    assign mirror_rst_n = mrst_n_q;
    assign irq_n        = !flt_q;
    assign mirror_en    = men_q;
    assign lv_supply_en = lv_q;
endmodule

// File: rtl/hv_rail_seq_chk.sv
// Checker for hv_rail_seq: rail ordering, discharge exclusion, array-reset and
// interrupt relations at the ports. Assumes nothing beyond the port behaviour.
module hv_rail_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic offs_en,
    input logic bias_en,
    input logic rset_en,
    input logic offs_dis,
    input logic bias_dis,
    input logic rset_dis,
    input logic mirror_rst_n,
    input logic irq_n,
    input logic lv_supply_en
);
    a_r5_bias_needs_offs: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en |-> offs_en);

    a_r5_rset_needs_bias: assert property (@(posedge clk) disable iff (!rst_n)
        rset_en |-> bias_en);

    a_r13_no_dis_while_on: assert property (@(posedge clk) disable iff (!rst_n)
        (offs_dis || bias_dis || rset_dis) |-> !(offs_en || bias_en || rset_en));

    a_r7_irq_low_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(fault));

    a_r6_mrst_low_without_offs: assert property (@(posedge clk) disable iff (!rst_n)
        !offs_en |-> !mirror_rst_n);

    a_r4_mrst_release_with_rset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mirror_rst_n) |-> rset_en);

    a_r9_rails_need_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !lv_supply_en |-> !(offs_en || bias_en || rset_en));
endmodule

bind hv_rail_seq hv_rail_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fault(fault),
    .offs_en(offs_en), .bias_en(bias_en), .rset_en(rset_en),
    .offs_dis(offs_dis), .bias_dis(bias_dis), .rset_dis(rset_dis),
    .mirror_rst_n(mirror_rst_n), .irq_n(irq_n), .lv_supply_en(lv_supply_en)
);

// File: tb/hv_rail_seq_tb_top.sv
// Bench for hv_rail_seq: register vector table, then directed sequence tests
// timing each port edge in exact cycles (20 clocks per ms, 2 clocks per fast tick).
module hv_rail_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MS = 20;
    localparam int FT = 2;

    localparam logic [9:0] M_OFFS = 10'h001;
    localparam logic [9:0] M_BIAS = 10'h002;
    localparam logic [9:0] M_RSET = 10'h004;
    localparam logic [9:0] M_DIS  = 10'h038;
    localparam logic [9:0] M_MRST = 10'h040;
    localparam logic [9:0] M_IRQ  = 10'h080;
    localparam logic [9:0] M_MEN  = 10'h100;
    localparam logic [9:0] M_LV   = 10'h200;

    // {we, waddr[2:0], wdata[7:0], raddr[2:0], expected[7:0]}
    localparam int NVEC = 13;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'h00, 3'd0, 8'd1},
        {1'b0, 3'd0, 8'h00, 3'd1, 8'd125},
        {1'b0, 3'd0, 8'h00, 3'd2, 8'd0},
        {1'b0, 3'd0, 8'h00, 3'd3, 8'd1},
        {1'b0, 3'd0, 8'h00, 3'd4, 8'd1},
        {1'b1, 3'd0, 8'hFE, 3'd0, 8'd0},
        {1'b1, 3'd0, 8'h03, 3'd0, 8'd1},
        {1'b1, 3'd7, 8'hAA, 3'd7, 8'd0},
        {1'b0, 3'd0, 8'h00, 3'd1, 8'd125},
        {1'b1, 3'd1, 8'h10, 3'd1, 8'h10},
        {1'b1, 3'd3, 8'h02, 3'd3, 8'd2},
        {1'b1, 3'd4, 8'h00, 3'd4, 8'd0},
        {1'b1, 3'd1, 8'd125, 3'd1, 8'd125}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       proj_en = 1'b0, lv_good = 1'b0, fault = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       offs_en, bias_en, rset_en, offs_dis, bias_dis, rset_dis;
    logic       mirror_rst_n, irq_n, mirror_en, lv_supply_en;
    logic [9:0] obs;

    int checks = 0;
    int fails = 0;
    int irq_bad = 0;
    int rset_bad = 0;
    bit watch_irq = 1'b0;
    bit watch_rset = 1'b0;
    int n;

    always #(CLK_PERIOD/2) clk = ~clk;

    hv_rail_seq #(.CLKS_PER_MS(MS), .CLKS_PER_FTICK(FT)) dut_i (
        .clk(clk), .rst_n(rst_n), .proj_en(proj_en), .lv_good(lv_good), .fault(fault),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .offs_en(offs_en), .bias_en(bias_en), .rset_en(rset_en),
        .offs_dis(offs_dis), .bias_dis(bias_dis), .rset_dis(rset_dis),
        .mirror_rst_n(mirror_rst_n), .irq_n(irq_n), .mirror_en(mirror_en),
        .lv_supply_en(lv_supply_en)
    );

    assign obs = {lv_supply_en, mirror_en, irq_n, mirror_rst_n,
                  rset_dis, bias_dis, offs_dis, rset_en, bias_en, offs_en};

    // Monitors for conditions that must hold over whole windows.
    always @(negedge clk) begin
        if (watch_irq && !irq_n) irq_bad++;
        if (watch_rset && rset_en) rset_bad++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Count negedges until (obs & m) == v; returns -1 if not seen within lim.
    task automatic wait_for(input logic [9:0] m, input logic [9:0] v, input int lim,
                            output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (((obs & m) != v) && cnt < lim);
        if ((obs & m) != v) cnt = -1;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs in reset and just after release
        chk("R1 reset outputs", int'(obs), 32'h0B8);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle outputs", int'(obs), 32'h0B8);

        // R1/R2: register vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22]) reg_wr(VEC[i][21:19], VEC[i][18:11]);
            @(negedge clk);
            reg_addr = VEC[i][10:8];
            @(negedge clk);
            chk(i < 5 ? "R1 register reset value" : "R2 register access",
                int'(reg_rdata), int'(VEC[i][7:0]));
        end
        // now: offset code 2, bias code 0, stop 125, discharge 0, fast enabled

        // R3: supply first, rails wait for lv_good
        @(negedge clk); proj_en = 1'b1;
        wait_for(M_LV, M_LV, 10, n);
        chk("R3 lv_supply_en after proj_en", n, 1);
        repeat (5) @(negedge clk);
        chk("R3 offset rail waits for lv_good", int'(obs & (M_OFFS | M_MEN)), 0);
        lv_good = 1'b1;
        wait_for(M_OFFS | M_MEN, M_OFFS | M_MEN, 10, n);
        chk("R3 offset rail and mirror_en after lv_good", n, 1);
        // R4: power-up gaps
        wait_for(M_BIAS, M_BIAS, 500, n);
        chk("R4 bias rail after offset-stage delay", n, 3 * MS);
        wait_for(M_RSET | M_MRST, M_RSET | M_MRST, 500, n);
        chk("R4 reset rail and array release after bias-stage delay", n, 1 * MS);

        // R6/R7: normal power-down
        repeat (4) @(negedge clk);
        watch_irq = 1'b1;
        proj_en = 1'b0;
        wait_for(M_BIAS | M_RSET, 0, 2000, n);
        chk("R6 bias and reset rails stop", n, 25 * MS + 1);
        chk("R6 offset rail still on", int'(obs & M_OFFS), int'(M_OFFS));
        wait_for(M_OFFS, 0, 2000, n);
        chk("R6 offset rail stops", n, 10 * MS);
        chk("R6 array reset low with offset stop", int'(obs & M_MRST), 0);
        wait_for(M_DIS, M_DIS, 2000, n);
        chk("R6 discharge delay", n, MS);
        chk("R13 discharge state outputs", int'(obs), 32'h3B8);
        wait_for(M_LV, 0, 10, n);
        chk("R6 supply off after discharge", n, 1);
        chk("R6 mirror_en low", int'(obs & M_MEN), 0);
        watch_irq = 1'b0;
        chk("R7 irq_n stayed high in normal power-down", irq_bad, 0);

        // R7/R8/R9: fast fault shutdown with stop code 125, discharge code 0
        @(negedge clk); proj_en = 1'b1;
        wait_for(M_RSET, M_RSET, 1000, n);
        repeat (3) @(negedge clk);
        fault = 1'b1;
        wait_for(M_IRQ, 0, 10, n);
        chk("R7 irq_n low after fault", n, 1);
        wait_for(M_BIAS | M_RSET, 0, 2000, n);
        chk("R8 stop delay", n, 126 * FT);
        chk("R8 offset rail kept", int'(obs & M_OFFS), int'(M_OFFS));
        wait_for(M_DIS, M_DIS, 100, n);
        chk("R9 discharge delay", n, FT);
        chk("R9 discharge outputs", int'(obs), 32'h338);
        wait_for(M_MEN | M_LV, 0, 10, n);
        chk("R9 mirror_en and supply fall", n, 1);

        // R10: standby holds, restart on clear
        repeat (50) @(negedge clk);
        chk("R10 standby held while fault", int'(obs), 32'h038);
        fault = 1'b0;
        wait_for(M_LV | M_IRQ, M_LV | M_IRQ, 10, n);
        chk("R10 restart supply and irq release", n, 1);
        wait_for(M_OFFS, M_OFFS, 10, n);
        chk("R10 offset rail restarts", n, 1);

        // R11: fast shutdown disabled
        wait_for(M_RSET, M_RSET, 1000, n);
        reg_wr(3'd0, 8'h00);
        fault = 1'b1;
        wait_for(M_IRQ, 0, 10, n);
        chk("R11 irq_n low", n, 1);
        fault = 1'b0;
        wait_for(M_BIAS | M_RSET, 0, 2000, n);
        chk("R11 normal stop timing", n, 25 * MS);
        wait_for(M_OFFS, 0, 2000, n);
        chk("R11 offset stop timing", n, 10 * MS);
        chk("R11 irq_n still low", int'(obs & M_IRQ), 0);
        wait_for(M_LV, 0, 2000, n);
        chk("R11 supply off", n, MS + 1);

        // R12: fault during power-up, reset rail never on
        reg_wr(3'd0, 8'h01);
        reg_wr(3'd1, 8'h00);
        wait_for(M_BIAS, M_BIAS, 1000, n);
        chk("R12 reached bias stage", int'(n > 0), 1);
        watch_rset = 1'b1;
        fault = 1'b1;
        wait_for(M_BIAS, 0, 100, n);
        chk("R12 bias rail stops", n, 1 + FT);
        wait_for(M_OFFS | M_DIS, M_DIS, 100, n);
        chk("R12 discharge", n, FT);
        repeat (5) @(negedge clk);
        watch_rset = 1'b0;
        chk("R12 reset rail stayed off", rset_bad, 0);
        chk("R12 standby", int'(obs), 32'h038);
        proj_en = 1'b0;
        fault = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 idle after clear without request", int'(obs), 32'h0B8);

        report();
        $finish;
    end
endmodule